// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (512 bytes)

This block models the target side of a two-wire serial EEPROM that holds 512 bytes. It oversamples the SCL and SDA lines with the system clock. It detects START and STOP conditions and matches a device byte against a fixed family code and two select bits that are set at build time. It then moves bytes in or out of the array, most significant bit first, and drives an acknowledge slot on every ninth clock. SDA is open-drain. The block only ever pulls the line low through `sda_oe`, and it samples the resolved line on `sda_in`.

A single 9-bit location pointer survives between transactions. A write sets the pointer, and every byte accepted or sent advances it. A read that has no address phase therefore continues where the last access stopped. To read from a chosen location, a master writes the address without data and then issues a repeated START with a read request. A write-protect input makes the top 256 locations read-only. The block shows a refused write only by withholding the acknowledge on the data byte.

Top module: `eeprom2w_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) restarts device-byte reception from any state, including mid-byte. A STOP (SDA rises while SCL is high) returns the block to idle with SDA released.
- R2: The device byte is, MSB first: 1010, then the two select bits (parameter `DEV_SEL`), then location bit 8, then R/W (1 = read). A matching device byte is acknowledged by pulling SDA low during the ninth clock.
- R3: A device byte whose upper six bits do not match gets no acknowledge. Every later byte is then ignored with SDA released until the next START.
- R4: In a write, the byte after the device byte sets the pointer to {device-byte bit 1, byte}. Each following data byte is acknowledged, stored at the pointer, and advances the pointer by one.
- R5: While `wp` is 1, the device and address bytes are still acknowledged. A data byte aimed at 0x100 to 0x1FF gets no acknowledge and leaves the array and the pointer unchanged. Locations 0x000 to 0x0FF stay writable.
- R6: A read with no address phase returns the byte at the pointer, which is the last accessed location plus one. Location bit 8 of a read device byte is ignored.
- R7: A selective read is a write of the device byte and the address byte, then a repeated START and a read device byte. It returns the byte at the chosen location.
- R8: After each byte is sent, a master acknowledge (SDA low on the ninth clock) makes the block send the next location. A master no-acknowledge leaves SDA released until the next START.
- R9: The pointer wraps from 0x1FF to 0x000 for both reads and writes.
- R10: Bytes move MSB first, and the block changes `sda_oe` only while SCL is low.
- R11: After reset, SDA is released, the pointer is 0 and every array byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Serial clock line from the master |
| sda_in | input | 1 | Resolved level of the data line |
| wp | input | 1 | 1 locks locations 0x100 to 0x1FF against writes |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The assertions assume that the master holds each SCL level for many system clocks. They also assume that it moves SDA only while SCL is low, except when it issues START or STOP. The check that `sda_oe` changes only while SCL is low relies on SCL staying low for at least two clocks after each falling edge. The bench keeps each SCL half period at ten clocks. It changes its own SDA only after SCL has been low for two clocks, and it drives every input a few nanoseconds after a clock edge.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int EEP_AW = 9;
    localparam int EEP_DW = 8;
    localparam int EEP_DEPTH = 1 << EEP_AW;
    localparam logic [3:0] EEP_FAMILY = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEV, ST_BADR, ST_WDAT, ST_ACK, ST_RDAT, ST_MACK, ST_WAIT
    } eep_st_e;

    typedef struct packed {
        eep_st_e            st;
        eep_st_e            nxt;
        logic [3:0]         cnt;
        logic [EEP_DW-1:0]  sh;
        logic [EEP_AW-1:0]  ptr;
        logic               hi;
        logic               oe;
        logic               mack;
    } eep_fsm_t;

    typedef struct packed {
        logic scl_s;
        logic sda_s;
        logic scl_p;
        logic sda_p;
    } eep_line_t;
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond
    import eep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev,
    output logic sda_bit
);
    eep_line_t line_d, line_q;

    always_comb begin
        line_d       = line_q;
        line_d.scl_s = scl_in;
        line_d.sda_s = sda_in;
        line_d.scl_p = line_q.scl_s;
        line_d.sda_p = line_q.sda_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 4'b1111;
        else        line_q <= line_d;
    end

    assign scl_rise = line_q.scl_s & ~line_q.scl_p;
    assign scl_fall = ~line_q.scl_s & line_q.scl_p;
    assign start_ev = line_q.scl_s & line_q.scl_p & line_q.sda_p & ~line_q.sda_s;
    assign stop_ev  = line_q.scl_s & line_q.scl_p & ~line_q.sda_p & line_q.sda_s;
    assign sda_bit  = line_q.sda_s;

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_rise && scl_fall) && !(start_ev && stop_ev)); // R1
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int AW = 9,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/eeprom2w_slave.sv
module eeprom2w_slave
    import eep_pkg::*;
#(
    parameter logic [1:0] DEV_SEL = 2'b10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic wp,
    output logic sda_oe
);
    localparam logic [EEP_AW-1:0] PTR_ONE = EEP_AW'(1);
    localparam eep_fsm_t FSM_RST = '{st: ST_IDLE, nxt: ST_IDLE, cnt: 4'd0,
                                     sh: '0, ptr: '0, hi: 1'b0, oe: 1'b0, mack: 1'b0};

    logic scl_rise, scl_fall, start_ev, stop_ev, sda_bit;
    logic              mem_we;
    logic [EEP_AW-1:0] mem_waddr;
    logic [EEP_DW-1:0] mem_wdata;
    logic [EEP_DW-1:0] mem_rdata;

    eep_fsm_t q, d;

    eep_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev), .sda_bit(sda_bit)
    );

    eep_array #(.AW(EEP_AW), .DW(EEP_DW)) u_array (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
        .wdata(mem_wdata), .raddr(q.ptr), .rdata(mem_rdata)
    );

    always_comb begin
        logic dev_match;
        d         = q;
        mem_we    = 1'b0;
        mem_waddr = q.ptr;
        mem_wdata = q.sh;
        dev_match = (q.sh[7:4] == EEP_FAMILY) && (q.sh[3:2] == DEV_SEL);
        if (start_ev) begin
            d.st  = ST_DEV;
            d.cnt = 4'd0;
            d.oe  = 1'b0;
        end else if (stop_ev) begin
            d.st  = ST_IDLE;
            d.cnt = 4'd0;
            d.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_DEV, ST_BADR, ST_WDAT: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[EEP_DW-2:0], sda_bit};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = 4'd0;
                        d.st  = ST_ACK;
                        if (q.st == ST_DEV) begin
                            if (!dev_match) begin
                                d.st = ST_WAIT;
                            end else begin
                                d.oe  = 1'b1;
                                d.hi  = q.sh[1];
                                d.nxt = q.sh[0] ? ST_RDAT : ST_BADR;
                            end
                        end else if (q.st == ST_BADR) begin
                            d.ptr = {q.hi, q.sh};
                            d.oe  = 1'b1;
                            d.nxt = ST_WDAT;
                        end else begin
                            if (wp && q.ptr[EEP_AW-1]) begin
                                d.st = ST_WAIT;
                            end else begin
                                mem_we = 1'b1;
                                d.ptr  = q.ptr + PTR_ONE;
                                d.oe   = 1'b1;
                                d.nxt  = ST_WDAT;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.st  = q.nxt;
                        d.oe  = 1'b0;
                        d.cnt = 4'd0;
                        if (q.nxt == ST_RDAT) begin
                            d.sh  = mem_rdata;
                            d.ptr = q.ptr + PTR_ONE;
                            d.oe  = ~mem_rdata[EEP_DW-1];
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe  = 1'b0;
                            d.st  = ST_MACK;
                            d.cnt = 4'd0;
                        end else begin
                            d.sh = {q.sh[EEP_DW-2:0], 1'b0};
                            d.oe = ~q.sh[EEP_DW-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_bit;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.st  = ST_RDAT;
                            d.sh  = mem_rdata;
                            d.ptr = q.ptr + PTR_ONE;
                            d.oe  = ~mem_rdata[EEP_DW-1];
                        end else begin
                            d.st = ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= FSM_RST;
        else        q <= d;
    end

    assign sda_oe = q.oe;

    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (q.st == ST_DEV && q.cnt == 4'd0 && !sda_oe)); // R1
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (q.st == ST_IDLE && !sda_oe)); // R1
    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT) |-> !sda_oe); // R3
    AST_PROTECT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !(wp && mem_waddr[EEP_AW-1])); // R5
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (q.ptr == $past(q.ptr) + PTR_ONE)); // R9
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_in); // R10
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= 4'd8); // R10
endmodule

// File: tb/eeprom2w_slave_bench.sv
`timescale 1ns/1ps
module eeprom2w_slave_bench;
    localparam int HALF = 10;
    localparam logic [1:0] SEL = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    assign sda_line = m_sda & ~sda_oe;

    always #5 clk = ~clk;

    eeprom2w_slave #(.DEV_SEL(SEL)) u_eeprom2w_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .wp(wp), .sda_oe(sda_oe)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int oe_viol = 0;
    bit timeout = 1'b0;
    logic [7:0] ref_mem [512];
    int ptr_m = 0;

    string exp_req[$];
    int    exp_val[$];
    int    got_val[$];

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_item(input string r, input int v);
        exp_req.push_back(r);
        exp_val.push_back(v);
    endtask

    task automatic observe(input int v);
        got_val.push_back(v);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            wait (got_val.size() > 0);
            begin
                string r;
                int e, g;
                r = exp_req.pop_front();
                e = exp_val.pop_front();
                g = got_val.pop_front();
                n_cmp++;
                if (g != e) begin
                    n_bad++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", r, g, e);
                end
            end
        end
    end

    // R10: slave output may change only while SCL is low
    logic oe_prev = 1'b0;
    always @(posedge clk) begin
        if (rst_n && sda_oe != oe_prev && m_scl) oe_viol++;
        oe_prev <= sda_oe;
    end

    function automatic logic [7:0] dev_byte(input logic [1:0] s, input logic a8, input logic rw);
        return {4'b1010, s, a8, rw};
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; tick(HALF);
        m_scl = 1'b1; tick(HALF);
        m_sda = 1'b0; tick(HALF);
        m_scl = 1'b0; tick(HALF);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(HALF);
        m_scl = 1'b1; tick(HALF);
        m_sda = 1'b1; tick(HALF);
    endtask

    task automatic clk_bit(input logic v);
        m_sda = v;   tick(HALF);
        m_scl = 1'b1; tick(HALF);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic send_byte(input logic [7:0] b, input string r, input logic exp_ack);
        logic ack;
        for (int i = 7; i >= 0; i--) clk_bit(b[i]);
        m_sda = 1'b1; tick(HALF);
        m_scl = 1'b1; tick(HALF / 2);
        ack = ~sda_line;
        tick(HALF / 2);
        m_scl = 1'b0; tick(2);
        expect_item(r, exp_ack);
        observe(ack);
    endtask

    task automatic recv_byte(input string r, input logic [7:0] expv, input logic mack);
        logic [7:0] v;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(HALF);
            m_scl = 1'b1; tick(HALF / 2);
            v[i] = sda_line;
            tick(HALF / 2);
            m_scl = 1'b0; tick(2);
        end
        m_sda = ~mack; tick(HALF);
        m_scl = 1'b1;  tick(HALF);
        m_scl = 1'b0;  tick(2);
        m_sda = 1'b1;
        expect_item(r, expv);
        observe(v);
    endtask

    task automatic write_run(input int a, input int n, input int seed);
        bus_start();
        send_byte(dev_byte(SEL, a[8], 1'b0), "R2", 1'b1);
        send_byte(a[7:0], "R4", 1'b1);
        ptr_m = a;
        for (int i = 0; i < n; i++) begin
            int ad;
            logic [7:0] v;
            ad = (a + i) % 512;
            v  = 8'((seed + i * 37) & 8'hFF);
            if (wp && ad >= 256) begin
                send_byte(v, "R5", 1'b0);
                break;
            end
            send_byte(v, (ad == 0) ? "R9" : "R4", 1'b1);
            ref_mem[ad] = v;
            ptr_m = (ad + 1) % 512;
        end
        bus_stop();
    endtask

    task automatic read_sel(input int a, input int n, input string r);
        bus_start();
        send_byte(dev_byte(SEL, a[8], 1'b0), "R7", 1'b1);
        send_byte(a[7:0], "R7", 1'b1);
        bus_start();
        send_byte(dev_byte(SEL, 1'b0, 1'b1), "R7", 1'b1);
        for (int i = 0; i < n; i++)
            recv_byte(r, ref_mem[(a + i) % 512], i < n - 1);
        ptr_m = (a + n) % 512;
        tick(4);
        expect_item("R8", 0);
        observe(sda_oe);
        bus_stop();
    endtask

    task automatic read_imm(input int n, input string r);
        bus_start();
        send_byte(dev_byte(SEL, 1'b1, 1'b1), "R6", 1'b1);
        for (int i = 0; i < n; i++)
            recv_byte(r, ref_mem[(ptr_m + i) % 512], i < n - 1);
        ptr_m = (ptr_m + n) % 512;
        bus_stop();
    endtask

    task automatic run_tests();
        for (int i = 0; i < 512; i++) ref_mem[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        expect_item("R11", 0); observe(sda_oe);
        read_imm(1, "R11");

        wp = 1'b0;
        write_run(16'h0FE, 4, 8'hA5);
        read_sel(16'h0FE, 4, "R8");
        read_imm(1, "R6");

        wp = 1'b1;
        write_run(16'h105, 2, 8'h3C);
        read_imm(1, "R5");
        write_run(16'h010, 2, 8'h5A);
        read_sel(16'h010, 2, "R5");
        read_imm(1, "R6");

        bus_start();
        send_byte(dev_byte(~SEL, 1'b0, 1'b0), "R3", 1'b0);
        send_byte(dev_byte(SEL, 1'b0, 1'b0), "R3", 1'b0);
        send_byte(8'h00, "R3", 1'b0);
        bus_stop();
        read_imm(2, "R3");

        wp = 1'b0;
        write_run(16'h1FE, 3, 8'h81);
        read_imm(1, "R9");
        read_sel(16'h1FF, 3, "R9");
        read_sel(16'h0C3, 2, "R10");

        bus_start();
        send_byte(dev_byte(SEL, 1'b0, 1'b0), "R1", 1'b1);
        clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
        bus_start();
        send_byte(dev_byte(SEL, 1'b0, 1'b1), "R1", 1'b1);
        recv_byte("R1", ref_mem[ptr_m], 1'b0);
        ptr_m = (ptr_m + 1) % 512;
        bus_stop();
        tick(3);
        expect_item("R1", 0); observe(sda_oe);

        expect_item("R10", 0); observe(oe_viol);
        wait (got_val.size() == 0);
        tick(2);
    endtask

    initial begin
        fork
            run_tests();
            begin
                tick(150000);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule